// File: doc/BRIEF.md
# Glitch-Free Gated Clock Divider

This block divides a master clock by a ratio N and sends the result to a single clock output. An output-enable input that is asynchronous to the master clock switches that output on and off. The enable is first registered on the rising master-clock edge. It then acts only at divider period boundaries, so the output never shows a shortened high or low phase when it starts or stops. A ratio of one bypasses the divider: the output is the master clock, gated by an enable flop that changes only while the master clock is low.

The block is used where a derived clock must start and stop cleanly on request, with a known latency. When enabled, every period starts fresh from its first high cycle. A ratio change while running takes effect at the next period start.

Top module: `clkgate_seq`

## Requirements
- R1: The enable input is registered on the rising master-clock edge. If it rises between edges p and p+1, the first output rising edge coincides with master edge p+2, which is one to two master periods after the enable rose.
- R2: For N of 2 or more, the output is high for floor(N/2) master cycles and low for the remaining N-floor(N/2) cycles, with periods back to back.
- R3: For N equal to 1, the output copies the master clock as whole pulses: high for the master high half and low for the master low half.
- R4: If the enable falls before the final master cycle of a period, the period in progress completes at full width and the output then stays low with no further rising edge.
- R5: If the enable falls during the final master cycle of a period, it is sampled on the boundary edge. Exactly one more full period is produced before the output stops.
- R6: For N equal to 1, an enable fall that meets setup to the next master edge produces exactly one further output pulse before the output stays low.
- R7: The ratio input is taken only at a period start. A change made mid-period leaves the current period's widths unchanged and sets the widths of the next period.
- R8: While disabled, the divider rests at its period-start state. Each enable begins a full-width first high phase.
- R9: Reset, active low and synchronous, drives the output low and clears the sampled enable. The output stays low while reset is held, even for N equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_async | input | 1 | Output enable, asynchronous to mclk |
| div_ratio | input | RATIO_W (10) | Divide ratio N, legal 1 to 1023 (0 is treated as 1) |
| clk_out | output | 1 | Gated divided clock |

## Verification
The disable decision and the period boundary can land on the same master edge. This happens when the enable fall is first sampled on the edge that ends a period, so stopping and starting a new period compete in one cycle. The bench provokes this by dropping the enable in each master cycle position of a period, including the last one, for several ratios. It judges each case by counting output rising edges after the fall: zero for earlier positions, exactly one for the final position, and one for the bypass ratio. In the same way, a ratio change is applied mid-period to show that the boundary edge takes the new ratio only when a new period starts.

// File: rtl/clkgate_seq_pkg.sv
// Package: shared constants and types for the gated clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package clkgate_seq_pkg;

    // Default width of the divide-ratio input.
    localparam int RATIO_W_DEF = 10;

    // Divider activity state.
    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

endpackage

// File: rtl/clkgate_seq_sampler.sv
// Module: registers the asynchronous output enable on the rising master edge.
// Assumes: a single sampling stage is accepted; a late edge only moves the
// decision by one master cycle, which is the documented behaviour.
module clkgate_seq_sampler (
    input  logic mclk,
    input  logic rst_n,
    input  logic oe_async,
    output logic en_smp
);

    // Capture the enable on each rising master edge; reset clears it.
    always_ff @(posedge mclk) begin
        if (!rst_n) en_smp <= 1'b0;
        else        en_smp <= oe_async;
    end

endmodule

// File: rtl/clkgate_seq_divider.sv
// Module: programmable divider that starts and stops only at period boundaries.
// Assumes: ratio of 0 is treated as 1; ratio is captured at each period start.
module clkgate_seq_divider
    import clkgate_seq_pkg::*;
#(
    parameter int W = RATIO_W_DEF
) (
    input  logic         mclk,
    input  logic         rst_n,
    input  logic         en_smp,
    input  logic [W-1:0] ratio,
    output dv_state_e    state,
    output logic         q,
    output logic [W-1:0] cnt,
    output logic [W-1:0] n_lat,
    output logic         one_mode
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] ratio_eff;
    logic [W-1:0] cnt_inc;
    logic [W-1:0] hi_len;
    logic         last;

    // Legalise ratio, derive the high-phase length and the end-of-period flag.
    always_comb begin
        ratio_eff = (ratio == '0) ? ONE : ratio;
        cnt_inc   = cnt + ONE;
        hi_len    = n_lat >> 1;
        last      = (cnt == n_lat - ONE);
    end

    // Bypass mode applies when a period is about to start with ratio 1,
    // or a bypass period is still running.
    always_comb begin
        if (state == DV_RUN && !last) one_mode = (n_lat == ONE);
        else                          one_mode = (ratio_eff == ONE);
    end

    // Advance the period or decide, on a boundary, to restart or stop.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            state <= DV_IDLE;
            q     <= 1'b0;
            cnt   <= '0;
            n_lat <= ONE;
        end else if (state == DV_IDLE || last) begin
            cnt <= '0;
            if (en_smp) begin
                state <= DV_RUN;
                n_lat <= ratio_eff;
                q     <= (ratio_eff != ONE);
            end else begin
                state <= DV_IDLE;
                q     <= 1'b0;
            end
        end else begin
            cnt <= cnt_inc;
            q   <= (cnt_inc < hi_len);
        end
    end

endmodule

// File: rtl/clkgate_seq_passgate.sv
// Module: gates the master clock for ratio 1 and merges it with the divider output.
// Assumes: the gate flop changes on the falling master edge, so it never cuts
// a master high pulse; the divider output is a registered, glitch-free level.
module clkgate_seq_passgate (
    input  logic mclk,
    input  logic rst_n,
    input  logic en_smp,
    input  logic one_mode,
    input  logic q_div,
    output logic en_g,
    output logic clk_out
);

    // Update the bypass gate while the master clock is low.
    always_ff @(negedge mclk) begin
        if (!rst_n) en_g <= 1'b0;
        else        en_g <= en_smp && one_mode;
    end

    // Combine the gated master clock with the divided clock.
    always_comb begin
        clk_out = (mclk & en_g) | q_div;
    end

endmodule

// File: rtl/clkgate_seq.sv
// Module: top of the glitch-free gated clock divider.
// Assumes: div_ratio is quasi-static; oe_async may change at any time.
module clkgate_seq
    import clkgate_seq_pkg::*;
#(
    parameter int RATIO_W = RATIO_W_DEF
) (
    input  logic               mclk,
    input  logic               rst_n,
    input  logic               oe_async,
    input  logic [RATIO_W-1:0] div_ratio,
    output logic               clk_out
);

    logic               en_smp;
    logic               en_g;
    logic               q;
    logic               one_mode;
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] n_lat;
    dv_state_e          state;

    clkgate_seq_sampler u_smp (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .oe_async (oe_async),
        .en_smp   (en_smp)
    );

    clkgate_seq_divider #(.W(RATIO_W)) u_div (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .en_smp   (en_smp),
        .ratio    (div_ratio),
        .state    (state),
        .q        (q),
        .cnt      (cnt),
        .n_lat    (n_lat),
        .one_mode (one_mode)
    );

    clkgate_seq_passgate u_gate (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .en_smp   (en_smp),
        .one_mode (one_mode),
        .q_div    (q),
        .en_g     (en_g),
        .clk_out  (clk_out)
    );

endmodule

// File: rtl/clkgate_seq_chk.sv
// Module: property checker bound to the gated clock divider top.
// Assumes: observes the divider state through the bind port list.
module clkgate_seq_chk #(
    parameter int W = 10
) (
    input logic         mclk,
    input logic         rst_n,
    input logic         en_smp,
    input logic         run,
    input logic         q,
    input logic [W-1:0] cnt,
    input logic [W-1:0] n_lat
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R9
    reset_clear_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(rst_n) |-> (!run && !q));

    // R8
    fresh_start_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(run) |-> (cnt == '0));

    // R7
    ratio_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && cnt != n_lat - ONE) |=> $stable(n_lat));

    // R4
    stop_at_boundary_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && cnt == n_lat - ONE && !en_smp) |=> (!run && !q));

    // R2
    cnt_bound_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        run |-> (cnt < n_lat));

    // R3
    pass_no_div_chk: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && n_lat == ONE) |-> !q);

endmodule

bind clkgate_seq clkgate_seq_chk #(.W(RATIO_W)) u_chk (
    .mclk   (mclk),
    .rst_n  (rst_n),
    .en_smp (en_smp),
    .run    (state == clkgate_seq_pkg::DV_RUN),
    .q      (q),
    .cnt    (cnt),
    .n_lat  (n_lat)
);

// File: tb/clkgate_seq_tb.sv
`timescale 1ns/1ps
module clkgate_seq_tb;

    localparam int TCLK = 10;

    typedef struct packed {
        int n;
        int rise_off;
        int fall_pos;
        int extra;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2, 3, 0, 0}, '{2, 8, 1, 1}, '{3, 3, 0, 0}, '{3, 8, 1, 0},
        '{3, 3, 2, 1}, '{5, 2, 1, 0}, '{5, 7, 4, 1}, '{8, 3, 3, 0},
        '{8, 6, 7, 1}, '{1, 3, 0, 1}, '{1, 8, 0, 1}
    };

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe = 1'b0;
    logic [9:0] ratio = 10'd3;
    logic       clk_out;

    int checks = 0;
    int fails = 0;
    int rise_cnt = 0;

    clkgate_seq u_dut (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .oe_async  (oe),
        .div_ratio (ratio),
        .clk_out   (clk_out)
    );

    always #(TCLK/2) mclk = ~mclk;

    always @(posedge clk_out) rise_cnt = rise_cnt + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drop the enable and let the block settle to idle.
    task automatic go_idle();
        @(posedge mclk); #3 oe = 1'b0;
        repeat (20) @(posedge mclk);
    endtask

    initial begin
        #(TCLK * 100000);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        time tp, t0, t1, t2, t3;
        int snap;
        longint hi_exp, lo_exp;

        // R9: output low under reset
        repeat (3) @(posedge mclk);
        #2 check(clk_out == 1'b0, "R9 reset output", clk_out, 0);
        #5 check(clk_out == 1'b0, "R9 reset output", clk_out, 0);
        @(posedge mclk); #3 rst_n = 1'b1;
        repeat (3) @(posedge mclk);
        #2 check(clk_out == 1'b0, "R9 idle after reset", clk_out, 0);

        // Table of enable/disable cases: R1, R2, R3, R8, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            go_idle();
            ratio = VECS[i].n[9:0];
            @(posedge mclk); #(VECS[i].rise_off) oe = 1'b1;
            tp = $time - VECS[i].rise_off;
            @(posedge clk_out);
            check(($time - tp) == 2*TCLK, "R1 enable latency", $time - tp, 2*TCLK);
            t0 = $time;
            @(negedge clk_out); t1 = $time;
            @(posedge clk_out); t2 = $time;
            if (VECS[i].n == 1) begin
                hi_exp = TCLK/2; lo_exp = TCLK/2;
            end else begin
                hi_exp = (VECS[i].n/2) * TCLK;
                lo_exp = VECS[i].n * TCLK - hi_exp;
            end
            check((t1 - t0) == hi_exp, "R2/R3/R8 first high width", t1 - t0, hi_exp);
            check((t2 - t1) == lo_exp, "R2/R3 low width", t2 - t1, lo_exp);
            #1;
            repeat (VECS[i].fall_pos) @(posedge mclk);
            #3 oe = 1'b0;
            snap = rise_cnt;
            repeat (VECS[i].n + 6) @(posedge mclk);
            if (VECS[i].n == 1)
                check((rise_cnt - snap) == VECS[i].extra, "R6 pulses after fall", rise_cnt - snap, VECS[i].extra);
            else if (VECS[i].extra == 1)
                check((rise_cnt - snap) == 1, "R5 one extra period", rise_cnt - snap, 1);
            else
                check((rise_cnt - snap) == 0, "R4 no extra period", rise_cnt - snap, 0);
            #2 check(clk_out == 1'b0, "R4 stays low", clk_out, 0);
        end

        // R7: ratio change mid-period applies at the next period
        go_idle();
        ratio = 10'd4;
        @(posedge mclk); #3 oe = 1'b1;
        @(posedge clk_out); t0 = $time;
        #3 ratio = 10'd6;
        @(negedge clk_out); t1 = $time;
        @(posedge clk_out); t2 = $time;
        @(negedge clk_out); t3 = $time;
        check((t1 - t0) == 2*TCLK, "R7 old high kept", t1 - t0, 2*TCLK);
        check((t2 - t1) == 2*TCLK, "R7 old low kept", t2 - t1, 2*TCLK);
        check((t3 - t2) == 3*TCLK, "R7 new high applied", t3 - t2, 3*TCLK);

        // R9: reset in bypass mode silences the output
        go_idle();
        ratio = 10'd1;
        @(posedge mclk); #3 oe = 1'b1;
        repeat (4) @(posedge mclk);
        #3 rst_n = 1'b0;
        repeat (2) @(posedge mclk);
        snap = rise_cnt;
        repeat (4) @(posedge mclk);
        check(rise_cnt == snap, "R9 no pulses in reset", rise_cnt - snap, 0);
        #2 check(clk_out == 1'b0, "R9 low in reset high half", clk_out, 0);
        #5 check(clk_out == 1'b0, "R9 low in reset low half", clk_out, 0);
        oe = 1'b0;
        @(posedge mclk); #3 rst_n = 1'b1;
        repeat (4) @(posedge mclk);
        #2 check(clk_out == 1'b0, "R9 idle after release", clk_out, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule